// File: doc/BRIEF.md
# Dual-Mode Bus Arbiter with Read Retry

This block decides which of several masters owns a shared on-chip bus. Each master pushes transaction descriptors (target slave, read or write, priority, data length) into a private request queue. The arbiter looks at the head of every queue and picks one owner. The pick uses either age within priority or a rotating visit list that software sets. The owner holds the bus through one address cycle and all of its data cycles, and only then can another master take over.

In the address cycle the arbiter checks the status of the target slave. If a read targets a slave that reports it is busy, the arbiter signals a retry and releases the bus. The read stays at the head of its queue and competes again with its original age, so only a master with a higher priority can get in ahead of it. A write always proceeds. Data movement and address decoding belong to neighbouring logic. This block only issues the grant, the phase flags, the target slave index and the retry pulse.

Top module: `bus_arb_top`

## Requirements
- R1: `mode_i` = 0 selects age-within-priority arbitration and 1 selects rotating-list arbitration. Any other value drives `mode_err_o` high and blocks every new grant. When the mode becomes legal again, arbitration resumes.
- R2: In mode 0 the arbiter picks the queue head with the largest priority. Among equal priorities it picks the head that entered its queue earliest. Heads that entered in the same cycle are ordered by the lower master index.
- R3: In mode 1 the arbiter scans the list `rr_order_i` from the current pointer position and picks the first listed master with a pending head. Entry k of the list occupies bits [2k+1:2k]. The pointer then moves to the position after the one served. Priority values have no effect in this mode.
- R4: At most one bit of `grant_o` is high at a time. The owner keeps the grant for one address cycle and then for (beats field + 1) data cycles. A data cycle completes only in a cycle where `data_rdy_i` is high.
- R5: Each master has an 8-entry request queue. A push to a full queue is dropped and never produces a grant.
- R6: When the bus is idle, a request pushed at clock edge k is in its address cycle after edge k+1. When other work is pending, the next address cycle follows the last data cycle of the previous owner with no idle cycle between them.
- R7: In the address cycle of a read, `retry_o` goes high when the target slave's `slv_stat_en_i` bit is set and its `slv_ready_i` bit is low. A slave whose `slv_stat_en_i` bit is clear is treated as ready.
- R8: A write is never retried, whatever the target slave's status.
- R9: After a retry the grant drops for exactly one cycle. The retried request stays at the head of its queue with its original age, and only a head with strictly higher priority can be granted ahead of it.
- R10: After reset all queues are empty, no grant or phase flag is high, and the rotating pointer is at list entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Arbitration policy select (0 age/priority, 1 rotating list) |
| rr_order_i | input | N_MST*MST_W | Visiting order list, entry k at [k*MST_W +: MST_W] |
| req_push_i | input | N_MST | Per-master push strobe |
| req_slv_i | input | N_MST*SLV_W | Target slave per master |
| req_rd_i | input | N_MST | 1 = read, 0 = write |
| req_prio_i | input | N_MST*PRIO_W | Priority per master, larger wins |
| req_beats_i | input | N_MST*BEAT_W | Data cycles minus one per master |
| slv_stat_en_i | input | N_SLV | Slave provides a status flag |
| slv_ready_i | input | N_SLV | Slave status flag, 1 = ready |
| data_rdy_i | input | 1 | Current data cycle completes |
| grant_o | output | N_MST | One-hot bus owner |
| addr_phase_o | output | 1 | Owner is in its address cycle |
| data_phase_o | output | 1 | Owner is in a data cycle |
| grant_slv_o | output | SLV_W | Target slave of the owner |
| retry_o | output | 1 | Current address cycle is retried |
| mode_err_o | output | 1 | Illegal policy value |

## Verification
Two events can land in the same cycle: a retry decision and a new request from a higher-priority master. Also, the final data cycle of one owner coincides with arbitration for the next owner. The bench builds a retry loop on a busy slave and injects a higher-priority write and lower-priority reads while the loop runs. It then judges the recorded grant sequence: the write must pass the retried read without being retried itself, and the lower-priority reads must wait until the retried read succeeds. For the handover, the bench holds a blocker on the bus while queues fill. After it releases the blocker, it requires consecutive address cycles exactly two cycles apart, in the order computed from priority and arrival rank.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ADDR = 2'd1, ST_DATA = 2'd2} arb_st_e;
  localparam logic [1:0] MODE_FCFS = 2'd0;
  localparam logic [1:0] MODE_RR   = 2'd1;
endpackage

// File: rtl/bus_arb_fifo.sv
module bus_arb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (cnt_q != CNT_W'(DEPTH));  // full: drop
  assign pop_ok  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign valid_o = (cnt_q != '0);
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick import bus_arb_pkg::*; #(
  parameter int N_MST  = 4,
  parameter int PRIO_W = 2,
  parameter int TS_W   = 8,
  localparam int MST_W = $clog2(N_MST)
) (
  input  logic [1:0]              mode_i,
  input  logic [N_MST-1:0]        head_vld_i,
  input  logic [N_MST*PRIO_W-1:0] head_prio_i,
  input  logic [N_MST*TS_W-1:0]   head_seq_i,
  input  logic [N_MST*MST_W-1:0]  rr_order_i,
  input  logic [MST_W-1:0]        rr_ptr_i,
  output logic                    vld_o,
  output logic [MST_W-1:0]        idx_o,
  output logic [MST_W-1:0]        rr_next_o,
  output logic                    err_o
);
  // a is older than b under modular stamp arithmetic
  function automatic logic older(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1];
  endfunction

  logic              f_vld;
  logic [MST_W-1:0]  f_idx;
  logic [PRIO_W-1:0] f_prio;
  logic [TS_W-1:0]   f_seq;

  always_comb begin
    f_vld  = 1'b0;
    f_idx  = '0;
    f_prio = '0;
    f_seq  = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (head_vld_i[i]) begin
        if (!f_vld
            || (head_prio_i[i*PRIO_W +: PRIO_W] > f_prio)
            || ((head_prio_i[i*PRIO_W +: PRIO_W] == f_prio)
                && older(head_seq_i[i*TS_W +: TS_W], f_seq))) begin
          f_vld  = 1'b1;
          f_idx  = MST_W'(i);
          f_prio = head_prio_i[i*PRIO_W +: PRIO_W];
          f_seq  = head_seq_i[i*TS_W +: TS_W];
        end
      end
    end
  end

  logic             r_vld;
  logic [MST_W-1:0] r_idx, r_next, rr_cand;
  int               rr_pos;

  always_comb begin
    r_vld   = 1'b0;
    r_idx   = '0;
    r_next  = rr_ptr_i;
    rr_pos  = 0;
    rr_cand = '0;
    for (int k = 0; k < N_MST; k++) begin
      rr_pos  = (int'(rr_ptr_i) + k) % N_MST;
      rr_cand = rr_order_i[rr_pos*MST_W +: MST_W];
      if (!r_vld && head_vld_i[rr_cand]) begin
        r_vld  = 1'b1;
        r_idx  = rr_cand;
        r_next = MST_W'((rr_pos + 1) % N_MST);
      end
    end
  end

  assign err_o     = (mode_i != MODE_FCFS) && (mode_i != MODE_RR);
  assign vld_o     = err_o ? 1'b0 : ((mode_i == MODE_RR) ? r_vld : f_vld);
  assign idx_o     = (mode_i == MODE_RR) ? r_idx : f_idx;
  assign rr_next_o = r_next;
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top import bus_arb_pkg::*; #(
  parameter int N_MST      = 4,
  parameter int N_SLV      = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int PRIO_W     = 2,
  parameter int BEAT_W     = 4,
  parameter int TS_W       = 8,
  localparam int MST_W     = $clog2(N_MST),
  localparam int SLV_W     = $clog2(N_SLV)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              mode_i,
  input  logic [N_MST*MST_W-1:0]  rr_order_i,
  input  logic [N_MST-1:0]        req_push_i,
  input  logic [N_MST*SLV_W-1:0]  req_slv_i,
  input  logic [N_MST-1:0]        req_rd_i,
  input  logic [N_MST*PRIO_W-1:0] req_prio_i,
  input  logic [N_MST*BEAT_W-1:0] req_beats_i,
  input  logic [N_SLV-1:0]        slv_stat_en_i,
  input  logic [N_SLV-1:0]        slv_ready_i,
  input  logic                    data_rdy_i,
  output logic [N_MST-1:0]        grant_o,
  output logic                    addr_phase_o,
  output logic                    data_phase_o,
  output logic [SLV_W-1:0]        grant_slv_o,
  output logic                    retry_o,
  output logic                    mode_err_o
);
  // queue entry layout, low to high
  localparam int OFF_SLV  = BEAT_W;
  localparam int OFF_RD   = OFF_SLV + SLV_W;
  localparam int OFF_PRIO = OFF_RD + 1;
  localparam int OFF_SEQ  = OFF_PRIO + PRIO_W;
  localparam int E_W      = OFF_SEQ + TS_W;

  arb_st_e             st_q;
  logic [MST_W-1:0]    own_q, rr_ptr_q;
  logic [SLV_W-1:0]    cur_slv_q;
  logic                cur_rd_q;
  logic [BEAT_W-1:0]   cnt_q;
  logic [TS_W-1:0]     seq_q;

  logic [N_MST-1:0]        head_vld, pop;
  logic [E_W-1:0]          head_data [N_MST];
  logic [N_MST*PRIO_W-1:0] head_prio;
  logic [N_MST*TS_W-1:0]   head_seq;

  logic             pick_vld;
  logic [MST_W-1:0] pick_idx, pick_rr_next;
  logic             retry, last_beat, take;

  for (genvar m = 0; m < N_MST; m++) begin : g_q
    logic [E_W-1:0] wdata;
    assign wdata = {seq_q,
                    req_prio_i[m*PRIO_W +: PRIO_W],
                    req_rd_i[m],
                    req_slv_i[m*SLV_W +: SLV_W],
                    req_beats_i[m*BEAT_W +: BEAT_W]};
    assign pop[m] = (st_q == ST_ADDR) && !retry && (own_q == MST_W'(m));

    bus_arb_fifo #(.WIDTH(E_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (req_push_i[m]),
      .data_i  (wdata),
      .pop_i   (pop[m]),
      .data_o  (head_data[m]),
      .valid_o (head_vld[m])
    );

    assign head_prio[m*PRIO_W +: PRIO_W] = head_data[m][OFF_PRIO +: PRIO_W];
    assign head_seq[m*TS_W +: TS_W]      = head_data[m][OFF_SEQ +: TS_W];
  end

  bus_arb_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .TS_W(TS_W)) u_pick (
    .mode_i      (mode_i),
    .head_vld_i  (head_vld),
    .head_prio_i (head_prio),
    .head_seq_i  (head_seq),
    .rr_order_i  (rr_order_i),
    .rr_ptr_i    (rr_ptr_q),
    .vld_o       (pick_vld),
    .idx_o       (pick_idx),
    .rr_next_o   (pick_rr_next),
    .err_o       (mode_err_o)
  );

  assign retry     = (st_q == ST_ADDR) && cur_rd_q
                     && slv_stat_en_i[cur_slv_q] && !slv_ready_i[cur_slv_q];
  assign last_beat = (st_q == ST_DATA) && data_rdy_i && (cnt_q == '0);
  assign take      = pick_vld && ((st_q == ST_IDLE) || last_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q <= '0;
    end else if (|req_push_i) begin
      seq_q <= seq_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      own_q     <= '0;
      cur_slv_q <= '0;
      cur_rd_q  <= 1'b0;
      cnt_q     <= '0;
      rr_ptr_q  <= '0;
    end else begin
      if (take) begin
        st_q      <= ST_ADDR;
        own_q     <= pick_idx;
        cur_slv_q <= head_data[pick_idx][OFF_SLV +: SLV_W];
        cur_rd_q  <= head_data[pick_idx][OFF_RD];
        cnt_q     <= head_data[pick_idx][BEAT_W-1:0];
        if (mode_i == MODE_RR) rr_ptr_q <= pick_rr_next;
      end else begin
        unique case (st_q)
          ST_ADDR: st_q <= retry ? ST_IDLE : ST_DATA;
          ST_DATA: begin
            if (data_rdy_i) begin
              if (cnt_q == '0) st_q <= ST_IDLE;
              else             cnt_q <= cnt_q - 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      grant_o[m] = (st_q != ST_IDLE) && (own_q == MST_W'(m));
    end
  end

  assign addr_phase_o = (st_q == ST_ADDR);
  assign data_phase_o = (st_q == ST_DATA);
  assign grant_slv_o  = cur_slv_q;
  assign retry_o      = retry;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int N_MST = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] grant_o,
  input logic             addr_phase_o,
  input logic             data_phase_o,
  input logic             retry_o,
  input logic             mode_err_o,
  input logic             data_rdy_i,
  input logic             cur_rd_i
);
  assert_one_owner_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_hold_on_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_phase_o && !data_rdy_i) |=> (data_phase_o && $stable(grant_o)));

  assert_addr_then_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_phase_o && !retry_o) |=> data_phase_o);

  assert_retry_read_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (addr_phase_o && cur_rd_i));

  assert_retry_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> (grant_o == '0));

  assert_mode_err_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_err_o && (grant_o == '0)) |=> (grant_o == '0));
endmodule

bind bus_arb_top bus_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .grant_o      (grant_o),
  .addr_phase_o (addr_phase_o),
  .data_phase_o (data_phase_o),
  .retry_o      (retry_o),
  .mode_err_o   (mode_err_o),
  .data_rdy_i   (data_rdy_i),
  .cur_rd_i     (cur_rd_q)
);

// File: tb/bus_arb_top_bench.sv
module bus_arb_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [1:0] mode_i;
  logic [7:0] rr_order_i;
  logic [3:0] req_push_i;
  logic [7:0] req_slv_i;
  logic [3:0] req_rd_i;
  logic [7:0] req_prio_i;
  logic [15:0] req_beats_i;
  logic [3:0] slv_stat_en_i;
  logic [3:0] slv_ready_i;
  logic       data_rdy_i;
  logic [3:0] grant_o;
  logic       addr_phase_o;
  logic       data_phase_o;
  logic [1:0] grant_slv_o;
  logic       retry_o;
  logic       mode_err_o;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int log_n = 0;
  int log_m [2048];
  bit log_r [2048];
  int log_c [2048];

  bus_arb_top u_bus_arb_top (
    .clk_i, .rst_ni, .mode_i, .rr_order_i, .req_push_i, .req_slv_i, .req_rd_i,
    .req_prio_i, .req_beats_i, .slv_stat_en_i, .slv_ready_i, .data_rdy_i,
    .grant_o, .addr_phase_o, .data_phase_o, .grant_slv_o, .retry_o, .mode_err_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int gidx(input logic [3:0] g);
    int r = -1;
    for (int i = 0; i < 4; i++) if (g[i]) r = i;
    return r;
  endfunction

  // record every address cycle, sampled away from both edges
  always begin
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    if (rst_ni && addr_phase_o && log_n < 2048) begin
      log_m[log_n] = gidx(grant_o);
      log_r[log_n] = retry_o;
      log_c[log_n] = cyc;
      log_n++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk_i);
    req_push_i = '0;
  endtask

  task automatic set_req(input int m, input int slv, input bit rd, input int prio, input int beats);
    req_push_i[m]        = 1'b1;
    req_slv_i[m*2 +: 2]  = slv[1:0];
    req_rd_i[m]          = rd;
    req_prio_i[m*2 +: 2] = prio[1:0];
    req_beats_i[m*4 +: 4] = beats[3:0];
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    req_push_i = '0;
    step;
    step;
    rst_ni = 1'b1;
    step;
  endtask

  initial begin
    rst_ni = 1'b0;
    mode_i = 2'd0;
    rr_order_i = 8'b11_10_01_00;
    req_push_i = '0;
    req_slv_i = '0;
    req_rd_i = '0;
    req_prio_i = '0;
    req_beats_i = '0;
    slv_stat_en_i = '0;
    slv_ready_i = '1;
    data_rdy_i = 1'b1;
    do_reset;

    // R10: reset state
    chk(grant_o == 4'b0, "R10 grant after reset", grant_o, 0);
    chk(!addr_phase_o && !data_phase_o, "R10 phases after reset", {addr_phase_o, data_phase_o}, 0);
    chk(!retry_o && !mode_err_o, "R10 retry/err after reset", {retry_o, mode_err_o}, 0);

    // R6 / R4: single write timing, beats field 2 -> 3 data cycles
    set_req(2, 3, 1'b0, 0, 2);
    step;
    chk(grant_o == 4'b0, "R6 no grant one edge after push", grant_o, 0);
    step;
    chk(grant_o == 4'b0100 && addr_phase_o, "R6 address cycle after second edge", grant_o, 4);
    chk(grant_slv_o == 2'd3, "R4 target slave", grant_slv_o, 3);
    for (int i = 0; i < 3; i++) begin
      step;
      chk(data_phase_o && grant_o == 4'b0100, "R4 data cycle held", grant_o, 4);
    end
    step;
    chk(grant_o == 4'b0, "R4 release after last data cycle", grant_o, 0);

    // R4: wait states extend the data cycle
    data_rdy_i = 1'b0;
    set_req(1, 0, 1'b0, 0, 0);
    step;
    step;
    for (int i = 0; i < 5; i++) step;
    chk(data_phase_o && grant_o == 4'b0010, "R4 held while data not ready", grant_o, 2);
    data_rdy_i = 1'b1;
    step;
    chk(grant_o == 4'b0, "R4 release after ready data cycle", grant_o, 0);

    // R2 / R6: priority and arrival sweep behind a blocker
    for (int it = 0; it < 64; it++) begin
      int pr [4];
      int rk [4];
      bit used [4];
      int exp_o [3];
      int arr [3];
      int a;
      int base;
      int best;
      pr[0] = 0;
      pr[1] = it % 4;
      pr[2] = (it / 4) % 4;
      pr[3] = (it / 16) % 4;
      a = it % 4;
      base = log_n;
      data_rdy_i = 1'b0;
      set_req(0, 0, 1'b0, 0, 0);
      step;
      if (a == 3) begin
        for (int m = 1; m < 4; m++) begin
          set_req(m, m, 1'b0, pr[m], 0);
          rk[m] = 0;
        end
        step;
      end else begin
        if (a == 0) begin arr[0] = 1; arr[1] = 2; arr[2] = 3; end
        else if (a == 1) begin arr[0] = 3; arr[1] = 1; arr[2] = 2; end
        else begin arr[0] = 2; arr[1] = 3; arr[2] = 1; end
        for (int j = 0; j < 3; j++) begin
          set_req(arr[j], arr[j], 1'b0, pr[arr[j]], 0);
          rk[arr[j]] = j;
          step;
        end
      end
      step;
      step;
      data_rdy_i = 1'b1;
      repeat (10) step;
      for (int m = 0; m < 4; m++) used[m] = 1'b0;
      for (int p = 0; p < 3; p++) begin
        best = -1;
        for (int m = 1; m < 4; m++) begin
          if (!used[m] && (best < 0 || pr[m] > pr[best]
              || (pr[m] == pr[best] && (rk[m] < rk[best] || (rk[m] == rk[best] && m < best)))))
            best = m;
        end
        used[best] = 1'b1;
        exp_o[p] = best;
      end
      chk(log_n - base == 4, "R2 grant count", log_n - base, 4);
      chk(log_m[base] == 0, "R2 blocker first", log_m[base], 0);
      for (int p = 0; p < 3; p++)
        chk(log_m[base+1+p] == exp_o[p], "R2 priority/age order", log_m[base+1+p], exp_o[p]);
      for (int p = 1; p < 3; p++)
        chk(log_c[base+1+p] - log_c[base+p] == 2, "R6 back-to-back handover",
            log_c[base+1+p] - log_c[base+p], 2);
    end

    // R5: ten pushes into one queue, eight survive
    begin
      int base;
      int n1;
      do_reset;
      mode_i = 2'd0;
      data_rdy_i = 1'b0;
      base = log_n;
      set_req(0, 0, 1'b0, 0, 0);
      step;
      for (int i = 0; i < 10; i++) begin
        set_req(1, 1, 1'b0, 1, 0);
        step;
      end
      step;
      data_rdy_i = 1'b1;
      repeat (30) step;
      n1 = 0;
      for (int i = base; i < log_n; i++) if (log_m[i] == 1) n1++;
      chk(n1 == 8, "R5 full queue drops extra pushes", n1, 8);
      chk(log_n - base == 9, "R5 total grants", log_n - base, 9);
    end

    // R3 / R10: all 24 visiting orders, priority ignored
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
              int ord [4];
              int base;
              ord[0] = a; ord[1] = b; ord[2] = c; ord[3] = d;
              do_reset;
              mode_i = 2'd1;
              data_rdy_i = 1'b1;
              rr_order_i = {d[1:0], c[1:0], b[1:0], a[1:0]};
              base = log_n;
              for (int m = 0; m < 4; m++) set_req(m, m, 1'b0, m, 0);
              step;
              for (int m = 0; m < 4; m++) set_req(m, m, 1'b0, m, 0);
              step;
              repeat (22) step;
              chk(log_n - base == 8, "R3 grant count", log_n - base, 8);
              chk(log_m[base] == ord[0], "R10 pointer starts at entry 0", log_m[base], ord[0]);
              for (int k = 1; k < 8; k++)
                chk(log_m[base+k] == ord[k%4], "R3 visiting order", log_m[base+k], ord[k%4]);
            end
          end

    // R7 / R8 / R9: retry loop on busy slave 1
    begin
      int base;
      int mid;
      int n_bad_retry;
      int n_m1_retry;
      int n_m3;
      int n_m3_retry;
      int n_early_low;
      do_reset;
      mode_i = 2'd0;
      data_rdy_i = 1'b1;
      slv_stat_en_i = 4'b0010;
      slv_ready_i = 4'b0000;
      base = log_n;
      set_req(1, 1, 1'b1, 2, 0);
      step;
      repeat (7) step;
      set_req(2, 0, 1'b1, 1, 0);
      set_req(0, 2, 1'b1, 0, 0);
      step;
      repeat (7) step;
      set_req(3, 1, 1'b0, 3, 1);
      step;
      repeat (7) step;
      mid = log_n;
      slv_ready_i = 4'b0010;
      repeat (12) step;
      n_bad_retry = 0; n_m1_retry = 0; n_m3 = 0; n_m3_retry = 0; n_early_low = 0;
      for (int i = base; i < log_n; i++) begin
        if (log_r[i] && log_m[i] != 1) n_bad_retry++;
        if (log_r[i] && log_m[i] == 1) n_m1_retry++;
        if (log_m[i] == 3) begin n_m3++; if (log_r[i]) n_m3_retry++; end
        if (i < mid && (log_m[i] == 2 || log_m[i] == 0)) n_early_low++;
      end
      chk(n_m1_retry >= 3, "R7 busy read retried", n_m1_retry, 3);
      chk(n_bad_retry == 0, "R7 only busy read retried", n_bad_retry, 0);
      chk(n_m3 == 1 && n_m3_retry == 0, "R8 write to busy slave not retried", n_m3_retry, 0);
      chk(log_c[base+1] - log_c[base] == 2, "R9 one idle cycle after retry",
          log_c[base+1] - log_c[base], 2);
      chk(n_early_low == 0, "R9 lower priority never passes retried read", n_early_low, 0);
      chk(log_m[log_n-3] == 1 && !log_r[log_n-3], "R9 retried read completes", log_m[log_n-3], 1);
      chk(log_m[log_n-2] == 2, "R9 next by priority", log_m[log_n-2], 2);
      chk(log_m[log_n-1] == 0 && !log_r[log_n-1], "R7 slave without status treated ready",
          log_r[log_n-1], 0);
      slv_stat_en_i = '0;
      slv_ready_i = '1;
    end

    // R1: illegal mode values
    begin
      int base;
      do_reset;
      mode_i = 2'd2;
      data_rdy_i = 1'b1;
      base = log_n;
      set_req(0, 0, 1'b0, 0, 0);
      step;
      repeat (4) step;
      chk(mode_err_o == 1'b1, "R1 error flag for mode 2", mode_err_o, 1);
      chk(grant_o == 4'b0, "R1 no grant in mode 2", grant_o, 0);
      mode_i = 2'd3;
      step;
      step;
      chk(mode_err_o == 1'b1, "R1 error flag for mode 3", mode_err_o, 1);
      chk(log_n == base, "R1 no address cycle under bad mode", log_n - base, 0);
      mode_i = 2'd0;
      repeat (4) step;
      chk(mode_err_o == 1'b0, "R1 flag clears", mode_err_o, 0);
      chk(log_n - base == 1, "R1 grant resumes", log_n - base, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule